// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block computes the address of the next instruction for a 32-bit fixed-length RISC core. It sees the current PC, the fetched instruction word and the two source register values, and it resolves the control-transfer instructions in the same cycle. The instructions it handles are compare-equal and compare-unequal branches, an absolute jump within the current 256 MiB region, a jump that also records a return address, and a jump through a register. Every other instruction advances the PC by one word.

The block is purely combinational. A fetch stage feeds its next-PC output straight back into the PC register. The link outputs go to the register-file write port, and the taken flag tells the front end that the sequential fetch must be discarded. Pipelining, delay slots, prediction and the rewriting of out-of-range branches are handled elsewhere.

Field positions in the instruction word: bits 31:26 hold the operation code, bits 25:21 and 20:16 hold the register fields, bits 15:0 hold the branch offset, bits 25:0 hold the jump index, and bits 5:0 hold the function code for operation code 0. In the text below, "seq" means PC + 4, taken modulo 2^32.

Top module: `branch_npc_unit`

## Requirements
- R1: For an operation code other than 0, 2, 3, 4 or 5, the next PC is seq, the taken flag is 0, the link write is 0 and the misaligned flag is 0. PC 0xFFFFFFFC wraps so that seq is 0.
- R2: With operation code 4 and equal register values, the taken flag is 1 and the next PC is seq + (sign-extended bits 15:0 shifted left by 2).
- R3: With operation code 5 and unequal register values, the taken flag is 1 and the next PC is formed as in R2.
- R4: When a branch under operation code 4 or 5 fails its condition, the next PC is seq and the taken flag is 0.
- R5: Offsets with bit 15 set move backward. For example, 0xFFFF gives seq − 4 and 0x8000 gives seq − 131072.
- R6: With operation code 2, the taken flag is 1 and the next PC is {seq[31:28], bits 25:0, 2'b00}. Bits 31:28 come from seq, so a jump placed in the last word of a region lands in the following region.
- R7: Operation code 3 produces the same target as R6. It also raises the link write with link register number 31 and link value seq.
- R8: Operation code 0 with function code 8 sets the taken flag to 1 and uses the rs register value as the next PC.
- R9: For the R8 instruction, the misaligned flag equals 1 exactly when bits 1:0 of the rs value are nonzero, and the unaligned value is still used as the next PC. For every other instruction the flag is 0.
- R10: Operation code 0 with any function code other than 8 behaves as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of the register named by bits 25:21 |
| rt_val_i | input | 32 | Value of the register named by bits 20:16 |
| next_pc_o | output | 32 | Address of the next instruction |
| taken_o | output | 1 | Control transfer away from seq |
| link_we_o | output | 1 | Write the return address to the register file |
| link_idx_o | output | 5 | Register number for the return address |
| link_val_o | output | 32 | Return address (seq) |
| jr_misalign_o | output | 1 | Register-jump target not word aligned |

## Verification
The hardest cases to reach are at the region boundary. A pseudo-direct jump must take its upper four bits from the incremented PC, not from the current PC, and the two differ only when the instruction sits in the last word of a region. The same PC value is also the point where a backward or forward branch crosses the boundary. The sweep therefore includes PCs 0x0FFFFFFC and 0xFFFFFFFC in its PC set. It crosses every operation code with those PCs, with offsets that have the sign bit set and clear, and with register pairs that are equal, unequal, aligned and misaligned. Because the jump index overlaps the register and offset fields, the same instruction words also exercise jump indices with high and low bits set.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int INSTR_W  = 32;
    localparam int OPC_W    = 6;
    localparam int IMM_W    = 16;
    localparam int JIDX_W   = 26;
    localparam int FUNCT_W  = 6;
    localparam int WORD_SH  = 2;

    localparam logic [OPC_W-1:0]   OPC_REGOP = 6'd0;
    localparam logic [OPC_W-1:0]   OPC_JMP   = 6'd2;
    localparam logic [OPC_W-1:0]   OPC_JLINK = 6'd3;
    localparam logic [OPC_W-1:0]   OPC_BREQ  = 6'd4;
    localparam logic [OPC_W-1:0]   OPC_BRNE  = 6'd5;
    localparam logic [FUNCT_W-1:0] FN_JREG   = 6'd8;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BREQ,
        FLOW_BRNE,
        FLOW_JMP,
        FLOW_JLINK,
        FLOW_JREG
    } flow_kind_e;

    typedef struct packed {
        flow_kind_e          kind;
        logic [IMM_W-1:0]    offset;
        logic [JIDX_W-1:0]   jidx;
    } flow_dec_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output flow_dec_t          dec_o
);
    logic [OPC_W-1:0]   opc;
    logic [FUNCT_W-1:0] fn;

    always_comb begin
        opc          = instr_i[INSTR_W-1 -: OPC_W];
        fn           = instr_i[FUNCT_W-1:0];
        dec_o.offset = instr_i[IMM_W-1:0];
        dec_o.jidx   = instr_i[JIDX_W-1:0];
        unique case (opc)
            OPC_BREQ:  dec_o.kind = FLOW_BREQ;
            OPC_BRNE:  dec_o.kind = FLOW_BRNE;
            OPC_JMP:   dec_o.kind = FLOW_JMP;
            OPC_JLINK: dec_o.kind = FLOW_JLINK;
            OPC_REGOP: dec_o.kind = (fn == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
            default:   dec_o.kind = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_branch_eval.sv
module npc_branch_eval
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  seq_pc_i,
    input  logic [IMM_W-1:0] offset_i,
    input  logic [XLEN-1:0]  rs_val_i,
    input  logic [XLEN-1:0]  rt_val_i,
    output logic [XLEN-1:0]  target_o,
    output logic             equal_o
);
    localparam int EXT_W = XLEN - IMM_W - WORD_SH;

    logic [XLEN-1:0] disp;

    always_comb begin
        disp     = {{EXT_W{offset_i[IMM_W-1]}}, offset_i, {WORD_SH{1'b0}}};
        target_o = seq_pc_i + disp;
        equal_o  = (rs_val_i == rt_val_i);
    end
endmodule

// File: rtl/npc_jump_target.sv
module npc_jump_target
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-JIDX_W-WORD_SH-1:0] region_i,
    input  logic [JIDX_W-1:0]              jidx_i,
    output logic [XLEN-1:0]                target_o
);
    always_comb begin
        target_o = {region_i, jidx_i, {WORD_SH{1'b0}}};
    end
endmodule

// File: rtl/branch_npc_unit.sv
module branch_npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int REG_W    = 5,
    parameter int LINK_REG = 31
) (
    input  logic [XLEN-1:0]    pc_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [XLEN-1:0]    rs_val_i,
    input  logic [XLEN-1:0]    rt_val_i,
    output logic [XLEN-1:0]    next_pc_o,
    output logic               taken_o,
    output logic               link_we_o,
    output logic [REG_W-1:0]   link_idx_o,
    output logic [XLEN-1:0]    link_val_o,
    output logic               jr_misalign_o
);
    localparam int               REGION_W = XLEN - JIDX_W - WORD_SH;
    localparam logic [XLEN-1:0]  STEP     = XLEN'(1 << WORD_SH);

    flow_dec_t       dec;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] jmp_target;
    logic            regs_equal;

    assign seq_pc = pc_i + STEP;

    npc_decode u_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    npc_branch_eval #(.XLEN(XLEN)) u_branch (
        .seq_pc_i (seq_pc),
        .offset_i (dec.offset),
        .rs_val_i (rs_val_i),
        .rt_val_i (rt_val_i),
        .target_o (br_target),
        .equal_o  (regs_equal)
    );

    npc_jump_target #(.XLEN(XLEN)) u_jump (
        .region_i (seq_pc[XLEN-1 -: REGION_W]),
        .jidx_i   (dec.jidx),
        .target_o (jmp_target)
    );

    always_comb begin
        next_pc_o     = seq_pc;
        taken_o       = 1'b0;
        link_we_o     = 1'b0;
        jr_misalign_o = 1'b0;
        unique case (dec.kind)
            FLOW_BREQ: begin
                if (regs_equal) begin
                    next_pc_o = br_target;
                    taken_o   = 1'b1;
                end
            end
            FLOW_BRNE: begin
                if (!regs_equal) begin
                    next_pc_o = br_target;
                    taken_o   = 1'b1;
                end
            end
            FLOW_JMP: begin
                next_pc_o = jmp_target;
                taken_o   = 1'b1;
            end
            FLOW_JLINK: begin
                next_pc_o = jmp_target;
                taken_o   = 1'b1;
                link_we_o = 1'b1;
            end
            FLOW_JREG: begin
                next_pc_o     = rs_val_i;
                taken_o       = 1'b1;
                jr_misalign_o = |rs_val_i[WORD_SH-1:0];
            end
            default: begin
                next_pc_o = seq_pc;
            end
        endcase
    end

    assign link_idx_o = REG_W'(LINK_REG);
    assign link_val_o = seq_pc;

endmodule

// File: rtl/branch_npc_unit_chk.sv
module branch_npc_unit_chk #(
    parameter int XLEN  = 32,
    parameter int REG_W = 5
) (
    input logic [XLEN-1:0]  pc_i,
    input logic [31:0]      instr_i,
    input logic [XLEN-1:0]  rs_val_i,
    input logic [XLEN-1:0]  rt_val_i,
    input logic [XLEN-1:0]  next_pc_o,
    input logic             taken_o,
    input logic             link_we_o,
    input logic [REG_W-1:0] link_idx_o,
    input logic [XLEN-1:0]  link_val_o,
    input logic             jr_misalign_o
);
    logic [5:0]      op;
    logic            is_jr;
    logic            is_ctl;
    logic [XLEN-1:0] nxt;
    logic [XLEN-1:0] brt;
    logic            known;

    always_comb begin
        op     = instr_i[31:26];
        is_jr  = (op == 6'd0) && (instr_i[5:0] == 6'd8);
        is_ctl = is_jr || (op == 6'd2) || (op == 6'd3) || (op == 6'd4) || (op == 6'd5);
        nxt    = pc_i + XLEN'(4);
        brt    = nxt + {{(XLEN-18){instr_i[15]}}, instr_i[15:0], 2'b00};
        known  = !$isunknown({pc_i, instr_i, rs_val_i, rt_val_i});
        if (known) begin
            p_seq_default_r1: assert (is_ctl || (next_pc_o == nxt && !taken_o && !link_we_o))
                else $error("sequential default violated");
            p_beq_taken_r2: assert (!(op == 6'd4 && rs_val_i == rt_val_i) || (taken_o && next_pc_o == brt))
                else $error("equal branch target wrong");
            p_bne_taken_r3: assert (!(op == 6'd5 && rs_val_i != rt_val_i) || (taken_o && next_pc_o == brt))
                else $error("unequal branch target wrong");
            p_fallthru_r4: assert (!((op == 6'd4 || op == 6'd5) && !taken_o) || next_pc_o == nxt)
                else $error("failed branch did not fall through");
            p_region_r6: assert (!(op == 6'd2 || op == 6'd3) ||
                                 (taken_o && next_pc_o[XLEN-1:XLEN-4] == nxt[XLEN-1:XLEN-4] && next_pc_o[1:0] == 2'b00))
                else $error("pseudo-direct region wrong");
            p_link_only_jal_r7: assert (!link_we_o || (op == 6'd3 && link_idx_o == 5'd31 && link_val_o == nxt))
                else $error("link write malformed");
            p_jr_forward_r8: assert (!is_jr || (taken_o && next_pc_o == rs_val_i))
                else $error("register jump not forwarded");
            p_misalign_r9: assert (jr_misalign_o == (is_jr && rs_val_i[1:0] != 2'b00))
                else $error("misaligned flag wrong");
        end
    end
endmodule

bind branch_npc_unit branch_npc_unit_chk #(.XLEN(XLEN), .REG_W(REG_W)) u_chk (
    .pc_i          (pc_i),
    .instr_i       (instr_i),
    .rs_val_i      (rs_val_i),
    .rt_val_i      (rt_val_i),
    .next_pc_o     (next_pc_o),
    .taken_o       (taken_o),
    .link_we_o     (link_we_o),
    .link_idx_o    (link_idx_o),
    .link_val_o    (link_val_o),
    .jr_misalign_o (jr_misalign_o)
);

// File: tb/branch_npc_unit_tb.sv
`timescale 1ns/1ps
module branch_npc_unit_tb;

    logic        clk = 1'b0;
    logic [31:0] pc_i, instr_i, rs_val_i, rt_val_i;
    logic [31:0] next_pc_o, link_val_o;
    logic        taken_o, link_we_o, jr_misalign_o;
    logic [4:0]  link_idx_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    branch_npc_unit u_dut (
        .pc_i          (pc_i),
        .instr_i       (instr_i),
        .rs_val_i      (rs_val_i),
        .rt_val_i      (rt_val_i),
        .next_pc_o     (next_pc_o),
        .taken_o       (taken_o),
        .link_we_o     (link_we_o),
        .link_idx_o    (link_idx_o),
        .link_val_o    (link_val_o),
        .jr_misalign_o (jr_misalign_o)
    );

    task automatic check_vec(input string req, input logic [31:0] pc, input logic [31:0] ins,
                             input logic [31:0] rs, input logic [31:0] rt,
                             input logic [31:0] e_next, input logic e_taken,
                             input logic e_we, input logic e_mis);
        logic ok;
        @(posedge clk);
        pc_i = pc; instr_i = ins; rs_val_i = rs; rt_val_i = rt;
        @(negedge clk);
        ok = (next_pc_o === e_next) && (taken_o === e_taken) &&
             (link_we_o === e_we) && (jr_misalign_o === e_mis);
        if (e_we)
            ok = ok && (link_idx_o === 5'd31) && (link_val_o === pc + 32'd4);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s pc=%h ins=%h: got next=%h tk=%b we=%b idx=%0d lv=%h mis=%b exp next=%h tk=%b we=%b idx=31 lv=%h mis=%b",
                     req, pc, ins, next_pc_o, taken_o, link_we_o, link_idx_o, link_val_o, jr_misalign_o,
                     e_next, e_taken, e_we, pc + 32'd4, e_mis);
        end
    endtask

    initial begin : main
        logic [31:0] pcs [5];
        logic [15:0] imms [7];
        logic [31:0] rsv [4];
        logic [31:0] rtv [4];
        pcs[0] = 32'h0000_0000; pcs[1] = 32'h0008_0000; pcs[2] = 32'h0FFF_FFFC;
        pcs[3] = 32'hFFFF_FFFC; pcs[4] = 32'h1000_0010;
        imms[0] = 16'h0000; imms[1] = 16'h0001; imms[2] = 16'h0008; imms[3] = 16'h7FFF;
        imms[4] = 16'h8000; imms[5] = 16'hFFF8; imms[6] = 16'hFFFF;
        rsv[0] = 32'h0040_0000; rtv[0] = 32'h0040_0000;
        rsv[1] = 32'h0000_0005; rtv[1] = 32'h0000_0006;
        rsv[2] = 32'hFFFF_FFFF; rtv[2] = 32'h0000_0001;
        rsv[3] = 32'h0000_0403; rtv[3] = 32'h0000_0403;

        // R1: quiet instruction (all-zero word, a shift with function 0) at PC 0
        check_vec("R1", 32'h0, 32'h0, 32'h0, 32'h0, 32'h4, 1'b0, 1'b0, 1'b0);
        // R5: backward branch by one word to itself
        check_vec("R5", 32'h0008_0000, {6'd4, 5'd1, 5'd2, 16'hFFFF}, 32'h7, 32'h7, 32'h0008_0000, 1'b1, 1'b0, 1'b0);
        // R5: most negative offset
        check_vec("R5", 32'h0010_0000, {6'd5, 5'd1, 5'd2, 16'h8000}, 32'h1, 32'h2, 32'h000E_0004, 1'b1, 1'b0, 1'b0);
        // R6: jump from last word of a region lands in the next region
        check_vec("R6", 32'h0FFF_FFFC, {6'd2, 26'h000_0010}, 32'h0, 32'h0, 32'h1000_0040, 1'b1, 1'b0, 1'b0);
        // R7: link write with maximal index
        check_vec("R7", 32'h2000_0100, {6'd3, 26'h3FF_FFFF}, 32'h0, 32'h0, 32'h2FFF_FFFC, 1'b1, 1'b1, 1'b0);
        // R9: misaligned register target still forwarded
        check_vec("R9", 32'h100, {6'd0, 5'd31, 15'd0, 6'd8}, 32'h0000_1002, 32'h0, 32'h0000_1002, 1'b1, 1'b0, 1'b1);
        // R1: wrap at top of address space
        check_vec("R1", 32'hFFFF_FFFC, {6'd8, 26'h0}, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);

        for (int op = 0; op < 64; op++) begin
            for (int p = 0; p < 5; p++) begin
                for (int m = 0; m < 7; m++) begin
                    for (int r = 0; r < 4; r++) begin
                        logic [31:0] ins, seq, bt, jt, e_next;
                        logic        e_tk, e_we, e_mis, eq;
                        string       req;
                        ins = {op[5:0], 5'h11, 5'h12, imms[m]};
                        seq = pcs[p] + 32'd4;
                        bt  = seq + {{14{imms[m][15]}}, imms[m], 2'b00};
                        jt  = {seq[31:28], ins[25:0], 2'b00};
                        eq  = (rsv[r] == rtv[r]);
                        e_next = seq; e_tk = 1'b0; e_we = 1'b0; e_mis = 1'b0; req = "R1";
                        if (op == 4 || op == 5) begin
                            if ((op == 4) == eq) begin
                                e_next = bt; e_tk = 1'b1;
                                req = imms[m][15] ? "R5" : ((op == 4) ? "R2" : "R3");
                            end else begin
                                req = "R4";
                            end
                        end else if (op == 2) begin
                            e_next = jt; e_tk = 1'b1; req = "R6";
                        end else if (op == 3) begin
                            e_next = jt; e_tk = 1'b1; e_we = 1'b1; req = "R7";
                        end else if (op == 0) begin
                            if (imms[m][5:0] == 6'd8) begin
                                e_next = rsv[r]; e_tk = 1'b1; e_mis = (rsv[r][1:0] != 2'b00);
                                req = e_mis ? "R9" : "R8";
                            end else begin
                                req = "R10";
                            end
                        end
                        check_vec(req, pcs[p], ins, rsv[r], rtv[r], e_next, e_tk, e_we, e_mis);
                    end
                end
            end
        end

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : watchdog
        #1_500_000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got running, expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule